// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a synthesizable on-chip model of a synchronous static RAM whose data bus never needs an idle cycle between a read and a write. Every control, address and byte-enable input is registered on the rising clock edge. The write data for a command reaches the bus in the same slot where read data for a command issued at that edge would appear. Any sequence of reads and writes can therefore be issued on back-to-back clocks.

A static mode pin selects the latency. In pipelined mode a read returns data two edges after its command edge, and write data is taken at that same edge. In flow-through mode both happen one edge after the command. A second static pin selects the order of the 4-beat bursts, which are stepped by an advance input: linear or interleaved. Output enable and sleep act on the data outputs without waiting for the clock. A clock-enable input freezes the whole pipeline. The storage is a small register array. Its word is built from 9-bit byte lanes, and each lane has its own write enable.

Top module: `zt_sram`

## Requirements
- R1: A new command is accepted at an edge only when `ce0`, `ce1` and `ce2` are all 1 and `adv` is 0. Otherwise the edge is a deselect, which neither writes the array nor drives read data.
- R2: With `pipe_mode`=1, a read accepted at edge k drives its word on `dq_out` from edge k+2. A write accepted at edge k stores the `wdata` present at edge k+2.
- R3: With `pipe_mode`=0, a read accepted at edge k drives its word from edge k+1. A write accepted at edge k stores the `wdata` present at edge k+1.
- R4: Reads and writes may be issued on consecutive edges in any mix, with no idle cycle. A read issued directly after a write to the same address returns the newly written data.
- R5: Lane i covers bits [9i+8:9i] of the word. On a write, only the lanes whose `lane_we` bit is 1 at the command edge are updated, and the other lanes keep their contents.
- R6: With `adv`=1, the previous burst continues, and `addr`, `we` and the chip enables are ignored. The address bits above bit 1 stay the same. The low two bits of beat n are (s+n) mod 4 when `burst_lin`=1 and s XOR n when `burst_lin`=0, where s is the start offset. An `adv` after a deselect is itself a deselect.
- R7: `oe`=0 forces `dq_drive` and `dq_out` to 0 at once, independent of the clock.
- R8: `sleep`=1 forces `dq_drive` and `dq_out` to 0 at once. Every edge while it is high is a deselect that also ends the current burst.
- R9: At an edge with `clk_en`=0, no state changes: the array, the pipeline, the burst and the output data all hold.
- R10: After reset, `dq_drive` is 0 and no command is in flight. The array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable; 0 holds all state |
| ce0 | input | 1 | Chip enable 0, active high |
| ce1 | input | 1 | Chip enable 1, active high |
| ce2 | input | 1 | Chip enable 2, active high |
| we | input | 1 | 1 = write command, 0 = read command |
| adv | input | 1 | 1 = continue current burst |
| addr | input | ADDR_W | Word address |
| lane_we | input | LANES | Per-lane write enables |
| wdata | input | DATA_W | Late write data |
| pipe_mode | input | 1 | Static: 1 pipelined, 0 flow-through |
| burst_lin | input | 1 | Static: 1 linear, 0 interleaved burst |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous sleep/deselect |
| dq_out | output | DATA_W | Read data, 0 when not driven |
| dq_drive | output | 1 | Read data is being driven |

## Verification
The bench aims at the write-then-read-same-address pair in both latency modes. A design that read the array before the deferred write landed would return stale lanes there. It also runs bursts that wrap past offset 3 in both orders, with the chip enables and `we` toggled during `adv` beats. An address unit that took those inputs, or that confused the two orders, would touch the wrong word. Stall cycles inside a read stream expose a pipeline that keeps advancing when `clk_en` is low, because the read data would arrive early or be lost. Flips of `oe` and `sleep` in mid-cycle catch outputs that respond only at the next edge.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
    localparam int BEAT_W = 2;

    // offset of beat n within a 4-word group
    function automatic logic [BEAT_W-1:0] beat_offset(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] n,
        input logic              linear
    );
        return linear ? (start + n) : (start ^ n);
    endfunction
endpackage

// File: rtl/zt_burst_beat.sv
module zt_burst_beat
    import zt_sram_pkg::*;
(
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    input  logic              linear,
    output logic [BEAT_W-1:0] offset
);
    assign offset = beat_offset(start, beat, linear);
endmodule

// File: rtl/zt_lane_merge.sv
module zt_lane_merge #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic [LANES*LANE_W-1:0] old_word,
    input  logic [LANES*LANE_W-1:0] new_word,
    input  logic [LANES-1:0]        lane_en,
    output logic [LANES*LANE_W-1:0] merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] =
            lane_en[g] ? new_word[g*LANE_W +: LANE_W] : old_word[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              ce0,
    input  logic              ce1,
    input  logic              ce2,
    input  logic              we,
    input  logic              adv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pipe_mode,
    input  logic              burst_lin,
    input  logic              oe,
    input  logic              sleep,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive
);
    localparam int DEPTH = 2 ** ADDR_W;

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  lanes;
    } cmd_t;

    typedef struct packed {
        cmd_t              s1;
        cmd_t              s2;
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] cnt;
        logic              bwr;
        logic              bact;
        logic [DATA_W-1:0] rd;
        logic              drv;
    } state_t;

    state_t st_d, st_q;
    cmd_t   dcmd;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_word, wr_word;
    logic [BEAT_W-1:0] cnt_inc, beat_off;
    logic              go_new, go_cont, wr_fire;

    // command in the data slot: stage 1 (flow-through) or stage 2 (pipelined)
    assign dcmd    = pipe_mode ? st_q.s2 : st_q.s1;
    assign rd_word = mem[dcmd.addr];
    assign wr_fire = clk_en && dcmd.vld && dcmd.wr;
    assign cnt_inc = st_q.cnt + 2'd1;

    zt_burst_beat u_beat (
        .start  (st_q.base[BEAT_W-1:0]),
        .beat   (cnt_inc),
        .linear (burst_lin),
        .offset (beat_off)
    );

    zt_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
        .old_word (rd_word),
        .new_word (wdata),
        .lane_en  (dcmd.lanes),
        .merged   (wr_word)
    );

    always_comb begin
        st_d     = st_q;
        go_new   = !sleep && !adv && ce0 && ce1 && ce2;
        go_cont  = !sleep && adv && st_q.bact;
        st_d.s1  = '0;
        st_d.s1.lanes = lane_we;
        if (go_new) begin
            st_d.s1.vld  = 1'b1;
            st_d.s1.wr   = we;
            st_d.s1.addr = addr;
            st_d.base    = addr;
            st_d.cnt     = '0;
            st_d.bwr     = we;
            st_d.bact    = 1'b1;
        end else if (go_cont) begin
            st_d.s1.vld  = 1'b1;
            st_d.s1.wr   = st_q.bwr;
            st_d.s1.addr = {st_q.base[ADDR_W-1:BEAT_W], beat_off};
            st_d.cnt     = cnt_inc;
        end else begin
            st_d.bact    = 1'b0;
        end
        st_d.s2  = st_q.s1;
        st_d.drv = dcmd.vld && !dcmd.wr;
        if (dcmd.vld && !dcmd.wr) begin
            st_d.rd = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (clk_en) begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_fire) begin
            mem[dcmd.addr] <= wr_word;
        end
    end

    assign dq_drive = st_q.drv && oe && !sleep;
    assign dq_out   = dq_drive ? st_q.rd : '0;

    // ---------------- assertions ----------------
    assert_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv && !(ce0 && ce1 && ce2)) |=> !st_q.s1.vld);

    assert_read_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.drv)) |-> $past(dcmd.vld && !dcmd.wr));

    assert_write_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && dcmd.vld && dcmd.wr) |=> !st_q.drv);

    assert_burst_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv && !sleep && st_q.bact) |=>
            (st_q.s1.vld && st_q.s1.addr[ADDR_W-1:BEAT_W] == $past(st_q.base[ADDR_W-1:BEAT_W])));

    assert_sleep_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && sleep) |=> (!st_q.s1.vld && !st_q.bact));

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en) |=> ($stable(st_q.rd) && $stable(st_q.drv) && $stable(st_q.s1)));
endmodule

// File: tb/zt_sram_bench.sv
module zt_sram_bench;
    localparam int AW = 6;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en = 1'b0, ce0 = 1'b0, ce1 = 1'b0, ce2 = 1'b0, we = 1'b0, adv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [LN-1:0] lane_we = '0;
    logic [DW-1:0] wdata = '0;
    logic pipe_mode = 1'b1, burst_lin = 1'b1, oe = 1'b0, sleep = 1'b0;
    logic [DW-1:0] dq_out;
    logic dq_drive;

    zt_sram u_zt_sram (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ce0(ce0), .ce1(ce1), .ce2(ce2),
        .we(we), .adv(adv), .addr(addr), .lane_we(lane_we), .wdata(wdata),
        .pipe_mode(pipe_mode), .burst_lin(burst_lin), .oe(oe), .sleep(sleep),
        .dq_out(dq_out), .dq_drive(dq_drive)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // staged inputs for the next cycle
    logic t_en, t_c0, t_c1, t_c2, t_we, t_adv, t_oe, t_sl;
    logic [AW-1:0] t_addr;
    logic [LN-1:0] t_ln;

    // reference model state
    logic [DW-1:0] m_mem [2**AW];
    logic          s1v, s1w, s2v, s2w;
    logic [AW-1:0] s1a, s2a;
    logic [LN-1:0] s1l, s2l;
    logic          b_act, b_wr;
    logic [AW-1:0] b_base;
    logic [1:0]    b_cnt;
    logic          e_drv;
    logic [DW-1:0] e_rd;

    function automatic logic [1:0] ref_off(input logic [1:0] s, input logic [1:0] n, input logic lin);
        logic [2:0] sum;
        sum = {1'b0, s} + {1'b0, n};
        if (lin) return sum[1:0];
        return {s[1] != n[1], s[0] != n[0]};
    endfunction

    task automatic check_out(input string tag);
        logic          xd;
        logic [DW-1:0] xo;
        xd = e_drv && oe && !sleep;
        xo = xd ? e_rd : '0;
        n_chk++;
        if (dq_drive !== xd || dq_out !== xo) begin
            n_bad++;
            $display("FAIL %s t=%0t drive=%0b data=%h expected drive=%0b data=%h",
                     tag, $time, dq_drive, dq_out, xd, xo);
        end
    endtask

    task automatic model_edge();
        logic dv, dw;
        logic [AW-1:0] da;
        logic [LN-1:0] dl;
        logic [1:0] nc;
        if (!clk_en) return;
        dv = pipe_mode ? s2v : s1v;
        dw = pipe_mode ? s2w : s1w;
        da = pipe_mode ? s2a : s1a;
        dl = pipe_mode ? s2l : s1l;
        if (dv && dw) begin
            for (int i = 0; i < LN; i++)
                if (dl[i]) m_mem[da][i*LW +: LW] = wdata[i*LW +: LW];
        end
        if (dv && !dw) begin
            e_rd  = m_mem[da];
            e_drv = 1'b1;
        end else begin
            e_drv = 1'b0;
        end
        s2v = s1v; s2w = s1w; s2a = s1a; s2l = s1l;
        if (!sleep && !adv && ce0 && ce1 && ce2) begin
            s1v = 1'b1; s1w = we; s1a = addr; s1l = lane_we;
            b_act = 1'b1; b_wr = we; b_base = addr; b_cnt = 2'd0;
        end else if (!sleep && adv && b_act) begin
            nc = b_cnt + 2'd1;
            s1v = 1'b1; s1w = b_wr; s1a = {b_base[AW-1:2], ref_off(b_base[1:0], nc, burst_lin)};
            s1l = lane_we; b_cnt = nc;
        end else begin
            s1v = 1'b0; b_act = 1'b0;
        end
    endtask

    task automatic tick(input string tag);
        @(negedge clk);
        clk_en = t_en; ce0 = t_c0; ce1 = t_c1; ce2 = t_c2; we = t_we; adv = t_adv;
        addr = t_addr; lane_we = t_ln; oe = t_oe; sleep = t_sl;
        wdata = {$urandom, $urandom};
        #1 check_out(tag);
        @(posedge clk);
        model_edge();
        #2 check_out(tag);
    endtask

    task automatic stage_idle();
        t_en = 1'b1; t_c0 = 1'b0; t_c1 = 1'b1; t_c2 = 1'b1; t_we = 1'b0; t_adv = 1'b0;
        t_addr = '0; t_ln = '1; t_oe = 1'b1; t_sl = 1'b0;
    endtask

    task automatic op(input logic w, input logic [AW-1:0] a, input logic [LN-1:0] l, input string tag);
        stage_idle();
        t_c0 = 1'b1; t_we = w; t_addr = a; t_ln = l;
        tick(tag);
    endtask

    task automatic nop(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            stage_idle();
            tick(tag);
        end
    endtask

    task automatic beat(input string tag);
        stage_idle();
        t_adv = 1'b1; t_c0 = $urandom_range(0, 1); t_c1 = $urandom_range(0, 1);
        t_we = $urandom_range(0, 1); t_addr = AW'($urandom); t_ln = '1;
        tick(tag);
    endtask

    task automatic do_reset(input logic pm, input logic bl);
        @(negedge clk);
        rst_n = 1'b0; pipe_mode = pm; burst_lin = bl; oe = 1'b1; sleep = 1'b0;
        clk_en = 1'b0; ce0 = 1'b0;
        s1v = 0; s2v = 0; s1w = 0; s2w = 0; s1a = '0; s2a = '0; s1l = '0; s2l = '0;
        b_act = 0; b_wr = 0; b_base = '0; b_cnt = '0; e_drv = 0; e_rd = '0;
        @(posedge clk);
        #2 check_out("R10");
        @(negedge clk);
        rst_n = 1'b1;
        #1 check_out("R10");
    endtask

    task automatic directed(input string lat);
        // R4 / latency: write then read same address back to back
        op(1'b1, 6'd5, 4'hF, lat);
        op(1'b0, 6'd5, 4'hF, "R4");
        op(1'b1, 6'd9, 4'hF, "R4");
        op(1'b0, 6'd9, 4'hF, "R4");
        op(1'b0, 6'd5, 4'hF, "R4");
        nop(3, lat);
        // R5 partial lanes
        op(1'b1, 6'd12, 4'b0101, "R5");
        op(1'b0, 6'd12, 4'hF, "R5");
        op(1'b1, 6'd12, 4'b1000, "R5");
        op(1'b0, 6'd12, 4'hF, "R5");
        nop(3, "R5");
        // R1 deselect: write attempt with ce2 low, then read back
        stage_idle(); t_c0 = 1; t_c2 = 0; t_we = 1; t_addr = 6'd12; tick("R1");
        op(1'b0, 6'd12, 4'hF, "R1");
        nop(3, "R1");
        // R6 read burst from offset 1, and write burst from offset 2
        op(1'b0, 6'd17, 4'hF, "R6");
        beat("R6"); beat("R6"); beat("R6"); beat("R6");
        op(1'b1, 6'd22, 4'hF, "R6");
        beat("R6"); beat("R6"); beat("R6");
        op(1'b0, 6'd20, 4'hF, "R6");
        beat("R6"); beat("R6"); beat("R6");
        nop(1, "R6");
        beat("R6");
        nop(3, "R6");
        // R9 stall inside a read stream
        op(1'b0, 6'd3, 4'hF, "R9");
        stage_idle(); t_en = 0; t_c0 = 1; t_we = 1; t_addr = 6'd3; tick("R9");
        op(1'b0, 6'd4, 4'hF, "R9");
        stage_idle(); t_en = 0; tick("R9");
        stage_idle(); t_en = 0; tick("R9");
        nop(3, "R9");
        // R7 output enable off while reads return
        op(1'b0, 6'd6, 4'hF, "R7");
        op(1'b0, 6'd7, 4'hF, "R7");
        stage_idle(); t_oe = 0; tick("R7");
        stage_idle(); t_oe = 0; tick("R7");
        nop(2, "R7");
        // R8 sleep: ignores a write, ends a burst
        op(1'b0, 6'd8, 4'hF, "R8");
        stage_idle(); t_sl = 1; t_c0 = 1; t_we = 1; t_addr = 6'd8; tick("R8");
        stage_idle(); t_sl = 1; t_adv = 1; tick("R8");
        beat("R8");
        op(1'b0, 6'd8, 4'hF, "R8");
        nop(3, "R8");
    endtask

    task automatic random_run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            t_en   = ($urandom_range(0, 9) != 0);
            t_c0   = ($urandom_range(0, 7) != 0);
            t_c1   = ($urandom_range(0, 15) != 0);
            t_c2   = 1'b1;
            t_we   = $urandom_range(0, 1);
            t_adv  = ($urandom_range(0, 3) == 0);
            t_addr = AW'($urandom);
            t_ln   = LN'($urandom);
            t_oe   = ($urandom_range(0, 9) != 0);
            t_sl   = ($urandom_range(0, 29) == 0);
            tick(tag);
        end
        nop(3, tag);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd1234);
        // pipelined, linear
        do_reset(1'b1, 1'b1);
        for (int a = 0; a < 2**AW; a++) op(1'b1, AW'(a), 4'hF, "R2");
        nop(3, "R2");
        directed("R2");
        random_run(400, "R2");
        // pipelined, interleaved
        do_reset(1'b1, 1'b0);
        directed("R2");
        random_run(300, "R6");
        // flow-through, linear
        do_reset(1'b0, 1'b1);
        directed("R3");
        random_run(400, "R3");
        // flow-through, interleaved
        do_reset(1'b0, 1'b0);
        directed("R3");
        random_run(300, "R4");
        finish_run();
    end
endmodule